// File: doc/BRIEF.md
# Synchronous SRAM Read Output Path

This block models how read data leaves a synchronous burst SRAM. A small behavioural register array sits behind a command stage and an output stage. At run time the path can either pass array data straight to the bus (flow-through) or hold it in an output register for one more clock (pipelined). A read can start a four-beat burst. Each later beat is requested with a burst-advance strobe, and the low two address bits wrap in linear order.

Deselects move through the same two stages as reads. The bus therefore keeps driving for one full cycle after a deselect is taken, and lets go only after the second rising edge, in either mode. An output-enable input and a sleep input act without a clock. Sleep also blocks every command, while the array keeps its contents. The mode pin is adopted only when no read is in flight, and the mode out of reset is pipelined.

Top module: `sram_rdpath`

## Requirements
- R1: In flow-through mode (adopted pin value 0), a read taken at rising edge k puts its data on `dq_out` with `dq_drive`=1 before edge k+1. Burst beats follow one per clock (2-1-1-1).
- R2: In pipelined mode (adopted pin value 1), a read taken at edge k shows its data with `dq_drive`=1 after edge k+1 and not before (3-1-1-1).
- R3: A read is `chip_en`=1, `addr_strobe`=1, `wr_en`=0. When `chip_en`=1, `addr_strobe`=0 and `burst_adv`=1 in the cycle right after a read or burst beat, the next beat is read. The beat address keeps the upper address bits and adds one to the low two bits modulo 4.
- R4: A deselect is any edge that takes no read or beat, for example `chip_en`=0. After a deselect at edge k, `dq_drive` stays 1 until edge k+1 and is 0 after edge k+1. In flow-through mode, the last beat stays on `dq_out` during that extra cycle.
- R5: `out_en`=0 forces `dq_drive` to 0 at once, with no clock edge. Raising it again restores drive of the current beat.
- R6: `sleep`=1 forces `dq_drive` to 0 at once. Reads and writes presented while it is high are ignored, and the array keeps its contents.
- R7: A command presented for the first edge after `sleep` falls is accepted normally.
- R8: During and after reset `dq_drive` is 0, and the path starts in pipelined mode whatever the level of `pipe_mode`.
- R9: `pipe_mode` is adopted only at an edge where neither stage holds a read and no read is being taken. A change at any other time has no effect on the burst in progress.
- R10: A write (`chip_en`=1, `addr_strobe`=1, `wr_en`=1) stores `wr_data` at `addr` on that edge, never drives the bus, and is visible to a read at the next edge.
- R11: `addr_strobe` takes priority over `burst_adv`, so a new address can be read on every clock with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through; adopted when idle |
| chip_en | input | 1 | Chip enable; low deselects |
| addr_strobe | input | 1 | Load `addr` and start a read or write |
| burst_adv | input | 1 | Request the next burst beat |
| wr_en | input | 1 | With `addr_strobe`, make the command a write |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Write data |
| out_en | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep request, active high |
| dq_out | output | DATA_W | Value presented on the data bus |
| dq_drive | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
Flow-through data is due in the cycle right after the edge that takes the read. Pipelined data is due one cycle later, and drive ends in the second cycle after a deselect in both modes. The bench changes inputs on the falling edge and compares outputs at the next falling edge, counting stages from the command edge, so each beat is checked in exactly the cycle it is due. Effects of `out_en` and `sleep` are checked half a nanosecond after the input changes, before any rising edge, which shows that they act without a clock. Ignored commands during sleep are checked by watching the bus in the cycle where an accepted read would have appeared, and by reading the untouched word back afterwards.

// File: rtl/sram_rdpath_pkg.sv
// Shared command encoding for the SRAM read output path.
package sram_rdpath_pkg;

    // Command decoded from the strobes in one cycle.
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_BURST = 2'd2,
        CMD_WRITE = 2'd3
    } cmd_e;

endpackage

// File: rtl/sram_rdpath_ctrl.sv
// Command stage: decodes strobes, holds the burst address and stage-1
// valid flag, and owns the adopted operating mode.
// Assumes ADDR_W >= BURST_W and synchronous use of all strobes.
module sram_rdpath_ctrl
    import sram_rdpath_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              chip_en,
    input  logic              addr_strobe,
    input  logic              burst_adv,
    input  logic              wr_en,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              s2_vld,
    output cmd_e              cmd,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              s1_vld,
    output logic              mode_pipe
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_bump;
    logic              busy;

    // Decode this cycle's command; sleep and chip disable both give idle.
    always_comb begin
        cmd = CMD_IDLE;
        if (!sleep && chip_en) begin
            if (addr_strobe) begin
                cmd = wr_en ? CMD_WRITE : CMD_READ;
            end else if (burst_adv && s1_vld) begin
                cmd = CMD_BURST;
            end
        end
    end

    // Next burst address: wrap inside the low BURST_W bits.
    generate
        if (BURST_W >= ADDR_W) begin : g_full_wrap
            assign addr_bump = addr_q + ADDR_W'(1);
        end else begin : g_low_wrap
            logic [BURST_W-1:0] beat_nxt;
            assign beat_nxt  = addr_q[BURST_W-1:0] + BURST_W'(1);
            assign addr_bump = {addr_q[ADDR_W-1:BURST_W], beat_nxt};
        end
    endgenerate

    // Path is idle when no read occupies or is entering either stage.
    assign busy = s1_vld || s2_vld || (cmd == CMD_READ);

    // Stage-1 register: read address and valid flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            s1_vld <= 1'b0;
        end else begin
            case (cmd)
                CMD_READ: begin
                    addr_q <= addr;
                    s1_vld <= 1'b1;
                end
                CMD_BURST: begin
                    addr_q <= addr_bump;
                    s1_vld <= 1'b1;
                end
                default: begin
                    s1_vld <= 1'b0;
                end
            endcase
        end
    end

    // Mode register: pipelined out of reset, pin adopted only when idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_pipe <= 1'b1;
        end else if (!busy) begin
            mode_pipe <= pipe_mode;
        end
    end

    assign rd_addr = addr_q;

endmodule

// File: rtl/sram_rdpath_array.sv
// Behavioural storage array: one synchronous write port and one
// combinational read port. Contents are not reset, so they survive
// sleep and reset alike.
module sram_rdpath_array #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a word on a write command.
    always_ff @(posedge clk) begin
        if (wr_req) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read the stage-1 address without a clock.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sram_rdpath_out.sv
// Output stage: data register, second deselect stage and bus drive.
// Flow-through shows array data while stage 1 is valid and then the
// registered copy. Pipelined shows only the registered copy. Drive is
// gated with no clock by output enable and sleep.
module sram_rdpath_out #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pipe,
    input  logic              s1_vld,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              out_en,
    input  logic              sleep,
    output logic              s2_vld,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);

    logic [DATA_W-1:0] data_q;
    logic              stage_drive;

    // Stage-2 register: follows stage 1 one clock later; sleep clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
        end else begin
            s2_vld <= s1_vld && !sleep;
        end
    end

    // Output data register: captures each beat read in stage 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (s1_vld) begin
            data_q <= rd_data;
        end
    end

    // Pick the bus value and the stage that keeps the bus driven.
    always_comb begin
        if (mode_pipe) begin
            dq_out      = data_q;
            stage_drive = s2_vld;
        end else begin
            dq_out      = s1_vld ? rd_data : data_q;
            stage_drive = s1_vld || s2_vld;
        end
    end

    // Asynchronous gating of the drive enable.
    assign dq_drive = stage_drive && out_en && !sleep;

endmodule

// File: rtl/sram_rdpath.sv
// Top of the SRAM read output path: command stage, array and output
// stage. Inputs other than out_en and sleep are taken on the rising edge.
module sram_rdpath
    import sram_rdpath_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              chip_en,
    input  logic              addr_strobe,
    input  logic              burst_adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              out_en,
    input  logic              sleep,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);

    cmd_e              cmd;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              s1_vld;
    logic              s2_vld;
    logic              mode_pipe;
    logic              wr_req;

    assign wr_req = (cmd == CMD_WRITE);

    sram_rdpath_ctrl #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pipe_mode   (pipe_mode),
        .chip_en     (chip_en),
        .addr_strobe (addr_strobe),
        .burst_adv   (burst_adv),
        .wr_en       (wr_en),
        .sleep       (sleep),
        .addr        (addr),
        .s2_vld      (s2_vld),
        .cmd         (cmd),
        .rd_addr     (rd_addr),
        .s1_vld      (s1_vld),
        .mode_pipe   (mode_pipe)
    );

    sram_rdpath_array #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) array_i (
        .clk     (clk),
        .wr_req  (wr_req),
        .wr_addr (addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    sram_rdpath_out #(
        .DATA_W (DATA_W)
    ) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_pipe (mode_pipe),
        .s1_vld    (s1_vld),
        .rd_data   (rd_data),
        .out_en    (out_en),
        .sleep     (sleep),
        .s2_vld    (s2_vld),
        .dq_out    (dq_out),
        .dq_drive  (dq_drive)
    );

endmodule

// File: rtl/sram_rdpath_chk.sv
// Property checker for sram_rdpath, attached by bind below.
// Watches ports and the stage flags that separate modules drive.
module sram_rdpath_chk (
    input logic clk,
    input logic rst_n,
    input logic chip_en,
    input logic out_en,
    input logic sleep,
    input logic dq_drive,
    input logic s1_vld,
    input logic s2_vld,
    input logic mode_pipe
);

    logic desel;
    assign desel = !chip_en || sleep;

    AST_SLEEP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_drive);  // R6

    AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !dq_drive);  // R5

    AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        desel ##1 desel |=> !dq_drive);  // R4

    AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> (dq_drive || !out_en || sleep));  // R4

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld || s2_vld) |=> $stable(mode_pipe));  // R9

    AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_pipe && !dq_drive));  // R8

    AST_FLOW_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_pipe && s1_vld && out_en && !sleep) |-> dq_drive);  // R1

endmodule

bind sram_rdpath sram_rdpath_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en   (chip_en),
    .out_en    (out_en),
    .sleep     (sleep),
    .dq_drive  (dq_drive),
    .s1_vld    (s1_vld),
    .s2_vld    (s2_vld),
    .mode_pipe (mode_pipe)
);

// File: tb/sram_rdpath_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
// Inputs change on the falling edge and outputs are compared at falling edges.
module sram_rdpath_tb_top;

    localparam int DW = 18;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pipe_mode;
    logic          chip_en;
    logic          addr_strobe;
    logic          burst_adv;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wr_data;
    logic          out_en;
    logic          sleep;
    logic [DW-1:0] dq_out;
    logic          dq_drive;

    logic [DW-1:0] shadow [1 << AW];
    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    sram_rdpath #(.DATA_W(DW), .ADDR_W(AW), .BURST_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .chip_en(chip_en),
        .addr_strobe(addr_strobe), .burst_adv(burst_adv), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .out_en(out_en), .sleep(sleep),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 1237 + 41) ^ (i << 11));
    endfunction

    task automatic chk(input string req, input logic exp_on,
                       input logic [DW-1:0] exp_d, input bit cmp_d);
        n_chk++;
        if (dq_drive !== exp_on || (cmp_d && dq_out !== exp_d)) begin
            n_err++;
            $display("FAIL %s: drive=%0b data=%h, expected drive=%0b data=%h",
                     req, dq_drive, dq_out, exp_on, exp_d);
        end
    endtask

    task automatic drive(input bit ce, input bit as, input bit adv, input bit we,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        chip_en = ce; addr_strobe = as; burst_adv = adv; wr_en = we;
        addr = a; wr_data = d;
    endtask

    task automatic settle(input bit pipe);
        repeat (3) begin
            @(negedge clk);
            pipe_mode = pipe;
            drive(1, 0, 0, 0, '0, '0);
        end
    endtask

    // Fill the array; writes must never drive the bus (R10).
    task automatic t_fill();
        for (int i = 0; i < (1 << AW); i++) begin
            @(negedge clk);
            drive(1, 1, 0, 1, AW'(i), pat(i));
            shadow[i] = pat(i);
        end
        @(negedge clk);
        drive(1, 0, 0, 0, '0, '0);
        @(negedge clk);
        chk("R10 write no drive", 1'b0, '0, 0);
    endtask

    // Four-beat burst; flip changes the mode pin mid-burst (R9).
    task automatic t_burst(input logic [AW-1:0] a, input bit pipe, input bit flip);
        settle(pipe);
        for (int n = 0; n <= 6; n++) begin
            @(negedge clk);
            if (n > 0) begin
                bit exp_on;
                int beat;
                string tag;
                logic [AW-1:0] ba;
                exp_on = pipe ? (n >= 2 && n <= 5) : (n <= 5);
                beat = 0;
                if (exp_on) beat = pipe ? ((n >= 5) ? 3 : n - 2) : ((n >= 4) ? 3 : n - 1);
                ba = {a[AW-1:2], a[1:0] + 2'(beat)};
                if (n == 6 || (n == 5 && !pipe)) tag = "R4 deselect";
                else if (flip) tag = "R9 mode held";
                else if (beat > 0) tag = "R3 burst beat";
                else tag = pipe ? "R2 pipe latency" : "R1 flow latency";
                chk(tag, exp_on, shadow[ba], exp_on);
            end
            if (n == 0) drive(1, 1, 0, 0, a, '0);
            else if (n <= 3) drive(1, 0, 1, 0, '0, '0);
            else if (n == 4) drive(0, 0, 0, 0, '0, '0);
            else drive(1, 0, 0, 0, '0, '0);
            if (flip && n == 1) pipe_mode = !pipe;
        end
    endtask

    // Output enable acts with no clock (R5).
    task automatic t_oe(input logic [AW-1:0] a);
        settle(0);
        @(negedge clk); drive(1, 1, 0, 0, a, '0);
        @(negedge clk); drive(1, 0, 1, 0, '0, '0);
        @(negedge clk); drive(1, 0, 1, 0, '0, '0);
        out_en = 1'b0;
        #0.5;
        chk("R5 oe off", 1'b0, '0, 0);
        @(negedge clk);
        drive(0, 0, 0, 0, '0, '0);
        out_en = 1'b1;
        #0.5;
        chk("R5 oe restore", 1'b1, shadow[{a[AW-1:2], a[1:0] + 2'd2}], 1);
        repeat (3) @(negedge clk);
    endtask

    // Sleep: no drive, commands ignored, contents kept, resume (R6, R7).
    task automatic t_sleep(input logic [AW-1:0] a, input logic [AW-1:0] w);
        settle(1);
        @(negedge clk); drive(1, 1, 0, 0, a, '0);
        @(negedge clk); drive(1, 0, 1, 0, '0, '0);
        @(negedge clk); drive(1, 0, 1, 0, '0, '0);
        chk("R2 before sleep", 1'b1, shadow[a], 1);
        sleep = 1'b1;
        #0.5;
        chk("R6 sleep off", 1'b0, '0, 0);
        @(negedge clk); drive(1, 1, 0, 1, w, ~shadow[w]);
        chk("R6 sleep held", 1'b0, '0, 0);
        @(negedge clk); drive(1, 1, 0, 0, a, '0);
        @(negedge clk);
        chk("R6 sleep held", 1'b0, '0, 0);
        sleep = 1'b0;
        drive(1, 1, 0, 0, w, '0);
        @(negedge clk);
        drive(0, 0, 0, 0, '0, '0);
        chk("R6 read in sleep ignored", 1'b0, '0, 0);
        @(negedge clk);
        chk("R7 resume R6 contents kept", 1'b1, shadow[w], 1);
        @(negedge clk);
        chk("R4 off after resume", 1'b0, '0, 0);
    endtask

    // Back-to-back single reads, pipelined (R11).
    task automatic t_b2b();
        settle(1);
        @(negedge clk); drive(1, 1, 1, 0, 6'd20, '0);
        @(negedge clk); drive(1, 1, 1, 0, 6'd33, '0);
        @(negedge clk); drive(0, 0, 0, 0, '0, '0);
        chk("R11 b2b first", 1'b1, shadow[20], 1);
        drive(1, 1, 0, 0, 6'd47, '0);
        @(negedge clk); drive(0, 0, 0, 0, '0, '0);
        chk("R11 b2b second", 1'b1, shadow[33], 1);
        @(negedge clk);
        chk("R11 b2b third", 1'b1, shadow[47], 1);
        @(negedge clk);
        chk("R4 b2b end", 1'b0, '0, 0);
    endtask

    // Write then read the same word on the next edge (R10).
    task automatic t_wr_rd();
        settle(1);
        @(negedge clk); drive(1, 1, 0, 1, 6'd50, 18'h2A5C3);
        shadow[50] = 18'h2A5C3;
        @(negedge clk); drive(1, 1, 0, 0, 6'd50, '0);
        @(negedge clk); drive(0, 0, 0, 0, '0, '0);
        chk("R10 write no drive", 1'b0, '0, 0);
        @(negedge clk);
        chk("R10 write visible", 1'b1, shadow[50], 1);
        repeat (2) @(negedge clk);
    endtask

    // Reset with pin low: first read is still pipelined (R8).
    task automatic t_reset_default();
        @(negedge clk);
        rst_n = 1'b0;
        pipe_mode = 1'b0;
        drive(0, 0, 0, 0, '0, '0);
        @(negedge clk);
        chk("R8 drive off in reset", 1'b0, '0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1, 1, 0, 0, 6'd5, '0);
        @(negedge clk);
        drive(0, 0, 0, 0, '0, '0);
        chk("R8 pipelined default", 1'b0, '0, 0);
        @(negedge clk);
        drive(1, 0, 0, 0, '0, '0);
        chk("R8 pipelined default data", 1'b1, shadow[5], 1);
        @(negedge clk);
        chk("R4 off after default read", 1'b0, '0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pipe_mode = 1'b1; out_en = 1'b1; sleep = 1'b0;
        drive(0, 0, 0, 0, '0, '0);
        repeat (3) @(negedge clk);
        chk("R8 reset state", 1'b0, '0, 0);
        rst_n = 1'b1;
        t_fill();
        t_burst(6'd9, 1, 0);
        t_burst(6'd14, 0, 0);
        t_burst(6'd27, 0, 1);
        t_oe(6'd40);
        t_sleep(6'd3, 6'd60);
        t_b2b();
        t_wr_rd();
        t_reset_default();
        t_burst(6'd37, 0, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule